// File: doc/BRIEF.md
# Per-Processor Interrupt Signalling Interface

This block sits between an interrupt distributor and a single processor. Every cycle the distributor offers the best pending interrupt for that processor, as an ID and an 8-bit priority. The interface compares that priority with a programmable threshold and with the priority of the interrupt the processor is already servicing. If the candidate passes both tests and signalling is switched on, the block raises a request line to the processor.

The processor talks to the block through a small register port. Reading the acknowledge location returns the candidate ID and pulses a strobe, so the distributor can move the interrupt from pending to active. The priority of that interrupt is pushed onto a four-entry stack of running priorities. A later write of the same ID to the completion location pops the stack and restores the previous running priority. Acknowledge and completion are separate steps, so higher-priority interrupts can nest while lower ones wait. A smaller priority value means more urgent.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset the request line is low, the control location (address 0) and the threshold location (address 1) read 0, and the running priority is idle (0xFF).
- R2: Bit 0 of the control location (address 0) enables signalling. While it is 0 the request line stays low.
- R3: The request line is high only when the candidate is valid and its priority is strictly below the 8-bit threshold held at address 1. Equal does not pass.
- R4: The request line is high only when the candidate priority is strictly below the running priority. The idle running priority is 0xFF.
- R5: A read of address 2 while the request line is high returns the candidate ID on regRdData one cycle later. In the cycle of the read, ackPulse is high and ackId carries that ID. The candidate priority becomes the running priority.
- R6: A read of address 2 while the request line is low returns 1023, gives no ackPulse and leaves the running priority unchanged.
- R7: A write to address 3 whose 10-bit data equals the ID of the most recently acknowledged active interrupt retires it. The running priority reverts to the priority of the interrupt below it, or to 0xFF if none remains.
- R8: A write to address 3 with any other ID, or with nothing active, is ignored. The running priority stays the same.
- R9: At most 4 interrupts can be active at once. With 4 active, the request line stays low and an acknowledge read returns 1023.
- R10: Reads of address 0 return the enable in bit 0 and reads of address 1 return the threshold in bits 7:0, one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| candValid | input | 1 | Distributor offers a pending interrupt |
| candId | input | 10 | ID of the offered interrupt |
| candPrio | input | 8 | Priority of the offered interrupt, lower is more urgent |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 control, 1 threshold, 2 acknowledge, 3 completion |
| regWrData | input | 10 | Write data |
| regRdData | output | 10 | Read data, valid the cycle after regRdEn |
| irqReq | output | 1 | Interrupt request to the processor |
| ackPulse | output | 1 | High for one cycle when an interrupt is acknowledged |
| ackId | output | 10 | ID being acknowledged, valid with ackPulse |

## Verification
The request line and ackPulse follow from the registered state and the current inputs, so they are due in the same cycle the stimulus is applied. The bench checks them one time step after driving inputs on the falling edge. Read data comes from a register and is due one cycle after the read strobe. The bench checks it at the following falling edge, against a value its model stored when the read was issued. A register write to the threshold, the control or the stack affects the request line from the next cycle on, and the model commits its state at the same rising edge.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_ACK  = 2'd2,
    ADDR_EOI  = 2'd3
  } regAddr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     push;
    logic     pop;
    logic     wrCtrl;
    logic     wrMask;
    logic     rdEn;
    regAddr_t rdSel;
  } strobe_t;

endpackage

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [ID_W-1:0]   regWrData,
  input  logic              candValid,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              enable,
  input  logic [PRIO_W-1:0] maskVal,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic [ID_W-1:0]   topId,
  input  logic              stkEmpty,
  input  logic              stkFull,
  output strobe_t           strb,
  output logic              irqReq
);

  regAddr_t addr;
  logic eligible;

  always_comb begin
    addr     = regAddr_t'(regAddr);
    eligible = candValid && enable && (candPrio < maskVal) &&
               (candPrio < runPrio) && !stkFull;
    irqReq   = eligible;

    strb.push   = regRdEn && (addr == ADDR_ACK) && eligible;
    strb.pop    = regWrEn && (addr == ADDR_EOI) && !stkEmpty &&
                  (regWrData == topId);
    strb.wrCtrl = regWrEn && (addr == ADDR_CTRL);
    strb.wrMask = regWrEn && (addr == ADDR_MASK);
    strb.rdEn   = regRdEn;
    strb.rdSel  = addr;
  end

endmodule

// File: rtl/cpuif_datapath.sv
module cpuif_datapath
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [ID_W-1:0]              regWrData,
  input  logic [ID_W-1:0]              candId,
  input  logic [PRIO_W-1:0]            candPrio,
  output logic                         enable,
  output logic [PRIO_W-1:0]            maskVal,
  output logic [PRIO_W-1:0]            runPrio,
  output logic [ID_W-1:0]              topId,
  output logic [$clog2(DEPTH+1)-1:0]   stkCnt,
  output logic                         stkEmpty,
  output logic                         stkFull,
  output logic [ID_W-1:0]              regRdData
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ID_W-1:0]   SPURIOUS  = '1;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  logic [ID_W-1:0]   idStk [DEPTH];
  logic [PRIO_W-1:0] prStk [DEPTH];
  logic [PTR_W-1:0]  topIdx;
  logic [PTR_W-1:0]  pushIdx;

  always_comb begin
    stkEmpty = (stkCnt == '0);
    stkFull  = (stkCnt == CNT_W'(DEPTH));
    topIdx   = PTR_W'(stkCnt - CNT_W'(1));
    pushIdx  = PTR_W'(stkCnt);
    runPrio  = stkEmpty ? IDLE_PRIO : prStk[topIdx];
    topId    = stkEmpty ? SPURIOUS  : idStk[topIdx];
  end

  // stack storage, one slot per nesting level
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idStk[g] <= '0;
        prStk[g] <= '0;
      end else if (strb.push && (pushIdx == PTR_W'(g))) begin
        idStk[g] <= candId;
        prStk[g] <= candPrio;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stkCnt <= '0;
    end else if (strb.push) begin
      stkCnt <= stkCnt + CNT_W'(1);
    end else if (strb.pop) begin
      stkCnt <= stkCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      maskVal <= '0;
    end else begin
      if (strb.wrCtrl) enable  <= regWrData[0];
      if (strb.wrMask) maskVal <= regWrData[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strb.rdEn) begin
      unique case (strb.rdSel)
        ADDR_CTRL: regRdData <= ID_W'(enable);
        ADDR_MASK: regRdData <= ID_W'(maskVal);
        ADDR_ACK:  regRdData <= strb.push ? candId : SPURIOUS;
        ADDR_EOI:  regRdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [ID_W-1:0]   regWrData,
  output logic [ID_W-1:0]   regRdData,
  output logic              irqReq,
  output logic              ackPulse,
  output logic [ID_W-1:0]   ackId
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t           strb;
  logic              enable;
  logic [PRIO_W-1:0] maskVal;
  logic [PRIO_W-1:0] runPrio;
  logic [ID_W-1:0]   topId;
  logic [CNT_W-1:0]  stkCnt;
  logic              stkEmpty;
  logic              stkFull;

  cpuif_ctrl #(.ID_W(ID_W), .PRIO_W(PRIO_W)) uCtrl (
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .candValid(candValid),
    .candPrio (candPrio),
    .enable   (enable),
    .maskVal  (maskVal),
    .runPrio  (runPrio),
    .topId    (topId),
    .stkEmpty (stkEmpty),
    .stkFull  (stkFull),
    .strb     (strb),
    .irqReq   (irqReq)
  );

  cpuif_datapath #(.ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWrData(regWrData),
    .candId   (candId),
    .candPrio (candPrio),
    .enable   (enable),
    .maskVal  (maskVal),
    .runPrio  (runPrio),
    .topId    (topId),
    .stkCnt   (stkCnt),
    .stkEmpty (stkEmpty),
    .stkFull  (stkFull),
    .regRdData(regRdData)
  );

  assign ackPulse = strb.push;
  assign ackId    = candId;

endmodule

// File: rtl/cpuif_checker.sv
module cpuif_checker #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              candValid,
  input logic [ID_W-1:0]   candId,
  input logic [PRIO_W-1:0] candPrio,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [1:0]        regAddr,
  input logic [ID_W-1:0]   regWrData,
  input logic [ID_W-1:0]   regRdData,
  input logic              irqReq,
  input logic              ackPulse,
  input logic              enable,
  input logic [PRIO_W-1:0] maskVal,
  input logic [PRIO_W-1:0] runPrio,
  input logic [ID_W-1:0]   topId,
  input logic [CNT_W-1:0]  stkCnt
);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !irqReq);

  a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (candValid && candPrio < maskVal));

  a_r4_preempt_only: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (candPrio < runPrio));

  a_r5_ack_returns_id: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd2 && irqReq) |=>
      (regRdData == $past(candId)));

  a_r5_ack_raises_prio: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> (runPrio == $past(candPrio)));

  a_r6_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd2 && !irqReq) |=>
      (regRdData == '1 && $stable(runPrio)));

  a_r8_eoi_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3 && (stkCnt == '0 || regWrData != topId))
      |=> ($stable(runPrio) && $stable(stkCnt)));

  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (stkCnt == CNT_W'(DEPTH)) |-> !irqReq);

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    stkCnt <= CNT_W'(DEPTH));

endmodule

bind cpu_irq_port cpuif_checker #(
  .ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .candValid(candValid),
  .candId   (candId),
  .candPrio (candPrio),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqReq   (irqReq),
  .ackPulse (ackPulse),
  .enable   (enable),
  .maskVal  (maskVal),
  .runPrio  (runPrio),
  .topId    (topId),
  .stkCnt   (stkCnt)
);

// File: tb/sim_cpu_irq_port.sv
`timescale 1ns/1ps
module sim_cpu_irq_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       candValid = 1'b0;
  logic [9:0] candId = '0;
  logic [7:0] candPrio = '0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [9:0] regWrData = '0;
  logic [9:0] regRdData;
  logic       irqReq;
  logic       ackPulse;
  logic [9:0] ackId;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // behavioural reference state
  int mEn = 0;
  int mMask = 0;
  int stkIdQ[$];
  int stkPrQ[$];
  bit rdPending = 0;
  int rdExpect = 0;
  string rdReq;

  always #2 clk = ~clk;

  cpu_irq_port u0 (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candId(candId),
    .candPrio(candPrio), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq), .ackPulse(ackPulse), .ackId(ackId)
  );

  function automatic int runP();
    return (stkPrQ.size() == 0) ? 255 : stkPrQ[$];
  endfunction

  task automatic check(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive on falling edge, check combinational outputs, commit model
  task automatic cyc(bit wr, bit rd, int addr, int data,
                     bit cv, int cid, int cpr, string req);
    bit expIrq;
    bit push;
    @(negedge clk);
    if (rdPending) check({rdReq, " rdData"}, int'(regRdData), rdExpect);
    rdPending = 0;
    regWrEn = wr; regRdEn = rd; regAddr = 2'(addr); regWrData = 10'(data);
    candValid = cv; candId = 10'(cid); candPrio = 8'(cpr);
    #1;
    expIrq = cv && (mEn != 0) && (cpr < mMask) && (cpr < runP()) &&
             (stkIdQ.size() < 4);
    check({req, " irqReq"}, int'(irqReq), int'(expIrq));
    push = rd && addr == 2 && expIrq;
    check({req, " ackPulse"}, int'(ackPulse), int'(push));
    if (push) check({req, " ackId"}, int'(ackId), cid);
    if (rd) begin
      rdPending = 1;
      rdReq = req;
      case (addr)
        0: rdExpect = mEn;
        1: rdExpect = mMask;
        2: rdExpect = push ? cid : 1023;
        default: rdExpect = 0;
      endcase
    end
    @(posedge clk);
    if (wr && addr == 0) mEn = data & 1;
    if (wr && addr == 1) mMask = data & 255;
    if (push) begin stkIdQ.push_back(cid); stkPrQ.push_back(cpr); end
    if (wr && addr == 3 && stkIdQ.size() > 0 && stkIdQ[$] == data) begin
      void'(stkIdQ.pop_back()); void'(stkPrQ.pop_back());
    end
  endtask

  task automatic idle(int cid, int cpr, string req);
    cyc(0, 0, 0, 0, 1, cid, cpr, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state
    cyc(0, 1, 0, 0, 1, 40, 8'hA0, "R1 ctrl");
    cyc(0, 1, 1, 0, 1, 40, 8'hA0, "R1 mask");
    cyc(0, 1, 2, 0, 1, 40, 8'hA0, "R6 ack at reset");
    // R2 enable gating
    cyc(1, 0, 1, 8'hF0, 1, 40, 8'hA0, "R2 write mask");
    idle(40, 8'hA0, "R2 disabled");
    cyc(1, 0, 0, 1, 1, 40, 8'hA0, "R2 enable");
    idle(40, 8'hA0, "R2 enabled");
    cyc(0, 0, 0, 0, 0, 40, 8'hA0, "R3 not valid");
    // R3 strict threshold
    cyc(1, 0, 1, 8'hA0, 1, 40, 8'hA0, "R3 mask eq");
    idle(40, 8'hA0, "R3 equal blocked");
    idle(40, 8'h9F, "R3 below passes");
    cyc(1, 0, 1, 8'hF0, 1, 40, 8'hA0, "R3 mask back");
    cyc(0, 1, 0, 0, 1, 40, 8'hA0, "R10 ctrl read");
    cyc(0, 1, 1, 0, 1, 40, 8'hA0, "R10 mask read");
    // R5 acknowledge and nesting
    cyc(0, 1, 2, 0, 1, 40, 8'hA0, "R5 ack 40");
    idle(41, 8'hA0, "R4 equal prio blocked");
    idle(41, 8'hB0, "R4 lower prio blocked");
    cyc(0, 1, 2, 0, 1, 50, 8'h80, "R5 ack 50");
    cyc(0, 1, 2, 0, 1, 60, 8'h60, "R5 ack 60");
    cyc(0, 1, 2, 0, 1, 70, 8'h40, "R5 ack 70");
    // R9 full stack
    idle(80, 8'h10, "R9 full blocks");
    cyc(0, 1, 2, 0, 1, 80, 8'h10, "R9 ack when full");
    // R8 mismatched completion
    cyc(1, 0, 3, 60, 1, 90, 8'h30, "R8 eoi wrong id");
    idle(90, 8'h50, "R8 still blocked");
    // R7 completion
    cyc(1, 0, 3, 70, 1, 90, 8'h50, "R7 eoi 70");
    idle(90, 8'h50, "R7 prio restored");
    idle(90, 8'h60, "R7 equal blocked");
    cyc(1, 0, 3, 60, 1, 90, 8'h70, "R7 eoi 60");
    cyc(1, 0, 3, 50, 1, 90, 8'h70, "R7 eoi 50");
    idle(90, 8'h90, "R7 under 0xA0");
    cyc(1, 0, 3, 40, 1, 90, 8'hA0, "R7 eoi 40");
    idle(90, 8'hEF, "R4 idle 0xFF");
    cyc(1, 0, 3, 40, 1, 90, 8'hEF, "R8 eoi empty");
    cyc(0, 1, 2, 0, 0, 90, 8'hEF, "R6 ack none");
    idle(90, 8'h10, "R6 no state change");
    cyc(1, 0, 0, 0, 1, 90, 8'h10, "R2 disable");
    idle(90, 8'h10, "R2 disabled again");
    cyc(0, 1, 2, 0, 1, 90, 8'h10, "R6 ack disabled");
    idle(90, 8'h10, "R10 drain");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule